// File: doc/BRIEF.md
# Rate-Generator Timer Channel

This block is one channel of a byte-programmed interval timer. Software programs it with two kinds of bus writes. A control byte goes to the control offset. Then a 16-bit count goes to the data offset as two byte writes, low byte first and high byte second. Once the count is complete, the channel divides its input clock by that count. It drives an active-low tick that stays high for most of each period and drops for exactly one clock once per period.

The control byte is split into four fields. Only one combination arms the channel: this channel's select code, low-then-high byte access, the rate-generator mode and binary counting. Any other combination is accepted silently and leaves the channel idle. Writing a new control byte always halts the channel until a complete count has been written again. Writing a new count while the channel runs does not disturb the current period: the new value is used from the next reload. A plain enable input pauses counting.

Top module: `pit_channel`

## Requirements
- R1: While reset is held and after it is released, `tick_n` is high and the channel stays idle, with no tick, until it is programmed.
- R2: The control byte is decoded as select = bits 7:6, access = bits 5:4, mode = bits 3:1, BCD = bit 0. The value 0x34 (select 0, access 2'b11, mode 3'b010, binary) arms the channel. After the low-byte write and then the high-byte write to offset 0, counting starts from the clock edge that takes the high byte. The first tick appears N-1 clock edges after that edge, for a count N >= 2.
- R3: While running with count N >= 2, `tick_n` is low for exactly one clock, and successive ticks are N clocks apart.
- R4: A count of 0 is treated as 65536: the first tick appears 65535 edges after the high-byte edge.
- R5: A control byte with a different select code, an access code other than 2'b11, a mode other than 3'b010, or BCD set, leaves the channel idle. Count writes that follow it produce no tick.
- R6: Any control write halts the channel at once (`tick_n` high on the next cycle). A following low-byte write alone does not restart it. The next high-byte write restarts it per R2.
- R7: A full count written while running is used at the next reload. The current period runs to its end with the old count.
- R8: While `cnt_en` is low the count holds and `tick_n` stays high. When it returns high, counting continues from the held value.
- R9: Writes to offsets 1 and 2 have no effect on the byte sequence or on the count.
- R10: A loaded count of 1 holds `tick_n` low on every clock while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per clock |
| wr_addr | input | 2 | Write offset: 3 = control, 0 = count data |
| wr_data | input | 8 | Write byte |
| cnt_en | input | 1 | Counting enable; low pauses the count |
| tick_n | output | 1 | Periodic active-low one-clock strobe |

## Verification
Counts are tried across several sizes: the minimum of 2, odd and even small values, values above one byte, and 0. Measuring both the delay to the first tick and the distance between ticks separates an off-by-one in the initial load from one in the reload. A sweep of control bytes changes each field in turn, so a decoder that ignores any single field shows up as a tick where none is due. Directed sequences cover the mid-run cases: halting, a half-written count, deferred count changes, a paused enable, stray offsets and a count of 1. Each one is told apart by where the next tick lands.

// File: rtl/pit_pkg.sv
// Shared types for the rate-generator timer channel.
// Assumes an 8-bit control byte with its fields packed from the MSB down.
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LOW   = 2'b01,
        ACC_HIGH  = 2'b10,
        ACC_BOTH  = 2'b11
    } access_e;

    localparam logic [2:0] MODE_RATE = 3'b010;

    typedef struct packed {
        logic [1:0] sel;
        access_e    access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

endpackage

// File: rtl/pit_ctrl_decode.sv
// Control byte decoder.
// Says whether a control byte arms this channel for binary rate generation
// with low-then-high byte loads. Purely combinational; assumes DATA_W is 8.
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CHANNEL_ID = 0
) (
    input  logic [DATA_W-1:0] ctrl_byte,
    output logic              arm_ok
);
    ctrl_word_t word;

    // Overlay the field layout and require every field to match.
    always_comb begin
        word   = ctrl_word_t'(ctrl_byte);
        arm_ok = (word.sel == 2'(CHANNEL_ID)) &&
                 (word.access == ACC_BOTH) &&
                 (word.mode == MODE_RATE) &&
                 !word.bcd;
    end
endmodule

// File: rtl/pit_load_seq.sv
// Count load sequencer.
// Tracks the armed state and the low/high byte order, keeps the low byte and
// the reload value, and raises single-cycle start and halt pulses.
// Assumes at most one write per clock.
module pit_load_seq #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int CTRL_OFS = 3,
    parameter int DATA_OFS = 0,
    localparam int CNT_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arm_ok,
    output logic              halt_pulse,
    output logic              load_pulse,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  reload_val
);
    logic              armed_q;
    logic              want_high_q;
    logic [DATA_W-1:0] low_q;
    logic              ctrl_wr;
    logic              data_wr;

    // Decode the target offset of the current write.
    always_comb begin
        ctrl_wr    = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));
        data_wr    = wr_en && (wr_addr == ADDR_W'(DATA_OFS)) && armed_q;
        halt_pulse = ctrl_wr;
        load_pulse = data_wr && want_high_q;
        load_val   = {wr_data, low_q};
    end

    // Keep the armed flag, byte order, low byte and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            want_high_q <= 1'b0;
            low_q       <= '0;
            reload_val  <= '0;
        end else if (ctrl_wr) begin
            armed_q     <= arm_ok;
            want_high_q <= 1'b0;
        end else if (data_wr) begin
            if (!want_high_q) begin
                low_q       <= wr_data;
                want_high_q <= 1'b1;
            end else begin
                reload_val  <= {wr_data, low_q};
                want_high_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pit_rate_core.sv
// Rate-generator down counter.
// Starts from a freshly loaded count, decrements while enabled, reloads
// from the stored value after the terminal state 1, and drives the
// active-low tick during the terminal state. Zero wraps, giving 65536 states.
module pit_rate_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_pulse,
    input  logic             load_pulse,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             cnt_en,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             tick_n
);
    localparam logic [CNT_W-1:0] TERMINAL = CNT_W'(1);

    // Start, halt, decrement and reload the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (halt_pulse) begin
            running <= 1'b0;
        end else if (load_pulse && !running) begin
            running <= 1'b1;
            cnt     <= load_val;
        end else if (running && cnt_en) begin
            cnt <= (cnt == TERMINAL) ? reload_val : cnt - 1'b1;
        end
    end

    // Strobe low while the enabled counter sits in its terminal state.
    always_comb tick_n = !(running && cnt_en && (cnt == TERMINAL));
endmodule

// File: rtl/pit_channel.sv
// Rate-generator timer channel, top level.
// Ties the control decoder, the load sequencer and the down counter
// together. Assumes byte-wide writes with a two-bit offset.
module pit_channel #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 2,
    parameter int CTRL_OFS   = 3,
    parameter int DATA_OFS   = 0,
    parameter int CHANNEL_ID = 0,
    localparam int CNT_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cnt_en,
    output logic              tick_n
);
    logic             arm_ok;
    logic             halt_pulse;
    logic             load_pulse;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] reload_val;
    logic             core_running;
    logic [CNT_W-1:0] core_cnt;

    pit_ctrl_decode #(.DATA_W(DATA_W), .CHANNEL_ID(CHANNEL_ID)) u_dec (
        .ctrl_byte (wr_data),
        .arm_ok    (arm_ok)
    );

    pit_load_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .arm_ok     (arm_ok),
        .halt_pulse (halt_pulse),
        .load_pulse (load_pulse),
        .load_val   (load_val),
        .reload_val (reload_val)
    );

    pit_rate_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_pulse (halt_pulse),
        .load_pulse (load_pulse),
        .load_val   (load_val),
        .reload_val (reload_val),
        .cnt_en     (cnt_en),
        .running    (core_running),
        .cnt        (core_cnt),
        .tick_n     (tick_n)
    );
endmodule

// File: rtl/pit_channel_chk.sv
// Property checker for the timer channel, bound into every instance.
// Watches the ports together with the counter state.
module pit_channel_chk #(
    parameter int ADDR_W   = 2,
    parameter int CTRL_OFS = 3,
    parameter int CNT_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              cnt_en,
    input logic              tick_n,
    input logic              running,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload_val
);
    logic ctrl_wr;
    always_comb ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

    AST_RESET_TICK_HIGH: assert property (@(posedge clk)
        !rst_n |=> tick_n);                                                 // R1
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> tick_n);                                               // R5
    AST_CTRL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (tick_n && !running));                                  // R6
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_n && reload_val != CNT_W'(1)) |=> tick_n);                   // R3
    AST_DECREMENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt_en && !ctrl_wr && cnt != CNT_W'(1))
        |=> (cnt == $past(cnt) - 1'b1));                                    // R4
    AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cnt_en) |=> $stable(cnt));                             // R8
endmodule

bind pit_channel pit_channel_chk #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cnt_en     (cnt_en),
    .tick_n     (tick_n),
    .running    (core_running),
    .cnt        (core_cnt),
    .reload_val (reload_val)
);

// File: tb/tb_pit_channel.sv
// Self-checking bench for the rate-generator timer channel.
module tb_pit_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cnt_en = 1'b1;
    logic       tick_n;

    int checks = 0;
    int errors = 0;

    pit_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_en(cnt_en), .tick_n(tick_n)
    );

    always #10 clk = ~clk; // 50 MHz

    // Stimulus table: control byte, count, and whether a tick is expected.
    localparam int NVEC = 10;
    localparam logic [7:0]  V_CTRL [NVEC] = '{8'h34, 8'h34, 8'h34, 8'h34, 8'h34,
                                              8'h74, 8'h36, 8'h35, 8'h24, 8'h3C};
    localparam logic [15:0] V_CNT  [NVEC] = '{16'd2, 16'd3, 16'd7, 16'd300, 16'd1000,
                                              16'd5, 16'd5, 16'd5, 16'd5, 16'd5};
    localparam logic        V_ACT  [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                              1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One write: driven at a falling edge, taken at the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] n);
        wr(2'd0, n[7:0]);
        wr(2'd0, n[15:8]);
    endtask

    // Rising edges until tick_n is seen low.
    task automatic edges_to_low(output int k);
        k = 0;
        while (tick_n === 1'b1 && k < 70000) begin
            @(posedge clk); @(negedge clk); k++;
        end
    endtask

    // Clocks for which tick_n stays low.
    task automatic low_width(output int w);
        w = 0;
        while (tick_n === 1'b0 && w < 70000) begin
            @(posedge clk); @(negedge clk); w++;
        end
    endtask

    // Count low samples over n clocks.
    task automatic watch(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (tick_n !== 1'b1) lows++;
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int k, w, lows, n;
        @(negedge clk);
        check(tick_n === 1'b1, "R1 tick high in reset", int'(tick_n), 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick_n === 1'b1, "R1 tick high after reset", int'(tick_n), 1);
        watch(20, lows);
        check(lows == 0, "R1 idle after reset", lows, 0);

        // Table walk: R2, R3, R5.
        for (int v = 0; v < NVEC; v++) begin
            wr(2'd3, V_CTRL[v]);
            load(V_CNT[v]);
            if (V_ACT[v]) begin
                n = int'(V_CNT[v]);
                edges_to_low(k);
                check(k == n - 1, "R2 first tick delay", k, n - 1);
                low_width(w);
                check(w == 1, "R3 tick width", w, 1);
                edges_to_low(k);
                check(k == n - 1, "R3 tick spacing", k + 1, n);
            end else begin
                watch(40, lows);
                check(lows == 0, "R5 unarmed control stays idle", lows, 0);
            end
        end

        // R6: control write halts; low byte alone does not restart.
        wr(2'd3, 8'h34);
        load(16'd5);
        repeat (3) @(negedge clk);
        wr(2'd3, 8'h34);
        check(tick_n === 1'b1, "R6 halted after control", int'(tick_n), 1);
        watch(20, lows);
        check(lows == 0, "R6 halted no tick", lows, 0);
        wr(2'd0, 8'd5);
        watch(20, lows);
        check(lows == 0, "R6 low byte alone no restart", lows, 0);
        wr(2'd0, 8'd0);
        edges_to_low(k);
        check(k == 4, "R6 restart after high byte", k, 4);

        // R7: new count used at the next reload.
        wr(2'd3, 8'h34);
        load(16'd10);
        edges_to_low(k);
        low_width(w);
        load(16'd4);
        edges_to_low(k);
        check(k == 7, "R7 current period keeps old count", k, 7);
        low_width(w);
        edges_to_low(k);
        check(k == 3, "R7 new count after reload", k + 1, 4);

        // R8: pause holds the count and keeps tick high.
        wr(2'd3, 8'h34);
        load(16'd6);
        edges_to_low(k);
        low_width(w);
        cnt_en = 1'b0;
        watch(10, lows);
        check(lows == 0, "R8 paused tick high", lows, 0);
        cnt_en = 1'b1;
        edges_to_low(k);
        check(k == 5, "R8 resumes from held count", k, 5);

        // R9: offsets 1 and 2 ignored between the two bytes.
        wr(2'd3, 8'h34);
        wr(2'd0, 8'd9);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd0);
        check(tick_n === 1'b1, "R9 stray offsets do not start", int'(tick_n), 1);
        wr(2'd0, 8'd0);
        edges_to_low(k);
        check(k == 8, "R9 count intact", k, 8);

        // R10: count of 1 keeps tick low.
        wr(2'd3, 8'h34);
        load(16'd1);
        watch(8, lows);
        check(lows == 8, "R10 count one always low", lows, 8);

        // R1: reset mid-run returns to idle.
        wr(2'd3, 8'h34);
        load(16'd3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tick_n === 1'b1, "R1 tick high under reset", int'(tick_n), 1);
        rst_n = 1'b1;
        watch(20, lows);
        check(lows == 0, "R1 idle after mid-run reset", lows, 0);

        // R4: count 0 gives 65536.
        wr(2'd3, 8'h34);
        load(16'd0);
        edges_to_low(k);
        check(k == 65535, "R4 zero count as 65536", k + 1, 65536);
        low_width(w);
        check(w == 1, "R4 tick width at full range", w, 1);

        summary();
        $finish;
    end
endmodule